// File: doc/BRIEF.md
# Bus Target Response Controller

This block is the slave half of a 32-bit multiplexed address/data bus of the PCI kind. It watches the bus for address phases. It claims those that fall inside its memory window, and configuration accesses that arrive while its chip select is high. It then steps through the data phases with its own ready strobe. The bus interface is modelled as separate input, output and output-enable lanes, so the pad ring can build the bidirectional pins.

Every data phase is passed to a simple local port as one word access: address, byte lanes, write data, a direction flag and a configuration flag. The local side answers with a one-cycle acknowledge. The controller inserts bus wait states until that acknowledge arrives. Bursts are capped at a parameterised number of phases, and the target ends longer bursts with a disconnect.

Top module: `pci_target_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no bus activity, claimN, slaveRdyN and haltN are high, and addrDataOe and localReq are low.
- R2: An address phase is claimed only for a memory command inside the window (read codes 4'h6, 4'hC, 4'hE; write codes 4'h7, 4'hF), or for a configuration command (4'hA read, 4'hB write) while cfgSel is high. The window is addrDataIn[31:WIN_LOG2] equal to WIN_BASE[31:WIN_LOG2]. Any other address phase leaves claimN high and raises no local request.
- R3: An address phase is the first clock at which cycleFrameN is sampled low after being high. For a claimed phase, claimN goes low two clocks later (medium decode).
- R4: A data phase completes only on a clock where masterRdyN and slaveRdyN are both low. Otherwise slaveRdyN stays asserted and the read data on addrDataOut is unchanged.
- R5: Read phase k fetches local address (captured address with bits 1:0 cleared) + 4k, modulo 2^LOCAL_AW, with all four byte lanes enabled. slaveRdyN is asserted with the returned word on addrDataOut only after localAck.
- R6: On a write phase, addrDataIn and the active-low lanes of cmdBeN are captured at completion. They are posted to the local port with the lanes inverted to active high, at local address base + 4k. slaveRdyN stays high until localAck returns.
- R7: At phase index BURST_MAX-1 of a burst, haltN is asserted together with slaveRdyN. It then stays low, with slaveRdyN high, until cycleFrameN is sampled high, so at most BURST_MAX phases complete.
- R8: After the final phase (completed with cycleFrameN high), or after a disconnect, claimN, slaveRdyN and haltN return high and addrDataOe low once the local side has finished.
- R9: localCfg is high for local accesses of a claimed configuration command and low for memory commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrDataIn | input | 32 | Address/data lanes as seen on the bus |
| cmdBeN | input | 4 | Command in the address phase, active-low byte lanes in data phases |
| cycleFrameN | input | 1 | Initiator cycle-active strobe, active low |
| masterRdyN | input | 1 | Initiator ready, active low |
| cfgSel | input | 1 | Configuration chip select, active high |
| addrDataOut | output | 32 | Read data driven onto the bus |
| addrDataOe | output | 1 | Enable for addrDataOut |
| claimN | output | 1 | Target claims the cycle, active low |
| slaveRdyN | output | 1 | Target ready, active low |
| haltN | output | 1 | Target stop request, active low |
| localAddr | output | LOCAL_AW | Local word address (byte address, bits 1:0 zero) |
| localByteEn | output | 4 | Local byte lanes, active high |
| localWrData | output | 32 | Local write data |
| localWrite | output | 1 | Local access is a write |
| localCfg | output | 1 | Local access belongs to a configuration command |
| localReq | output | 1 | Local access request, held until acknowledged |
| localRdData | input | 32 | Local read data, valid with localAck |
| localAck | input | 1 | One-cycle local completion |

## Verification
The bench builds the block with LOCAL_AW of 8, a 1 KB window at 32'h3400 (WIN_LOG2 of 10) and BURST_MAX of 4. These small values let a sweep of every command code against window hit/miss and chip select finish quickly. Bursts of one to six phases then reach the disconnect on the fourth phase, both below and beyond the cap. A start address near the top of the 8-bit local space makes the address wrap within a burst. Local latencies of zero to two cycles and initiator stalls of zero or one cycle cover both sides inserting wait states.

// File: rtl/pci_target_pkg.sv
package pci_target_pkg;

  localparam logic [3:0] CMD_MEM_RD      = 4'h6;
  localparam logic [3:0] CMD_MEM_WR      = 4'h7;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'hC;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'hE;
  localparam logic [3:0] CMD_MEM_WR_INV  = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_FETCH,
    ST_PRESENT,
    ST_ACCEPT,
    ST_POST,
    ST_DRAIN
  } tgtState_e;

  typedef struct packed {
    logic loadAddr;
    logic stepAddr;
    logic takeWrite;
    logic takeRead;
  } dpStrobe_t;

  function automatic logic cmdIsMem(logic [3:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE) ||
           (c == CMD_MEM_WR) || (c == CMD_MEM_WR_INV);
  endfunction

  function automatic logic cmdIsCfg(logic [3:0] c);
    return c[3:1] == 3'b101;
  endfunction

endpackage

// File: rtl/pci_target_dp.sv
module pci_target_dp
  import pci_target_pkg::*;
#(
  parameter int          LOCAL_AW = 12,
  parameter logic [31:0] WIN_BASE = 32'h8000_0000,
  parameter int          WIN_LOG2 = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                rdMode,
  input  logic [31:0]         addrDataIn,
  input  logic [3:0]          cmdBeN,
  input  logic [31:0]         localRdData,
  output logic                winHit,
  output logic [31:0]         addrDataOut,
  output logic [LOCAL_AW-1:0] localAddr,
  output logic [3:0]          localByteEn,
  output logic [31:0]         localWrData
);

  localparam int WIN_TAG_W = 32 - WIN_LOG2;

  logic [LOCAL_AW-1:0] addrReg;
  logic [31:0]         wrReg;
  logic [31:0]         rdReg;
  logic [3:0]          laneReg;

  assign winHit = addrDataIn[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
      rdReg   <= '0;
      laneReg <= '0;
    end else begin
      if (strobe.loadAddr) addrReg <= {addrDataIn[LOCAL_AW-1:2], 2'b00};
      else if (strobe.stepAddr) addrReg <= addrReg + LOCAL_AW'(4);
      if (strobe.takeWrite) begin
        wrReg   <= addrDataIn;
        laneReg <= ~cmdBeN;
      end
      if (strobe.takeRead) rdReg <= localRdData;
    end
  end

  assign localAddr   = addrReg;
  assign localWrData = wrReg;
  assign localByteEn = rdMode ? 4'hF : laneReg;
  assign addrDataOut = rdReg;

  // the window tag must leave at least one address bit to compare
  initial begin
    a_r2_window_width : assert (WIN_TAG_W > 0 && LOCAL_AW >= 3);
  end

endmodule

// File: rtl/pci_target_fsm.sv
module pci_target_fsm
  import pci_target_pkg::*;
#(
  parameter int BURST_MAX = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cycleFrameN,
  input  logic      masterRdyN,
  input  logic [3:0] cmdBeN,
  input  logic      cfgSel,
  input  logic      winHit,
  input  logic      localAck,
  output dpStrobe_t strobe,
  output logic      claimN,
  output logic      slaveRdyN,
  output logic      haltN,
  output logic      addrDataOe,
  output logic      localReq,
  output logic      localWrite,
  output logic      localCfg
);

  localparam int CNT_W = $clog2(BURST_MAX) + 1;
  localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(BURST_MAX - 1);

  tgtState_e        state;
  logic             prevFrameN;
  logic             finalSeen;
  logic [CNT_W-1:0] phaseCnt;

  logic addrPhase, memHit, cfgHit, hit, xfer, lastPhase;

  assign addrPhase = (state == ST_IDLE) && prevFrameN && !cycleFrameN;
  assign memHit    = winHit && cmdIsMem(cmdBeN);
  assign cfgHit    = cfgSel && cmdIsCfg(cmdBeN);
  assign hit       = memHit || cfgHit;
  assign xfer      = !slaveRdyN && !masterRdyN;
  assign lastPhase = phaseCnt == LAST_PHASE;

  always_comb begin
    strobe.loadAddr  = addrPhase && hit;
    strobe.takeRead  = (state == ST_FETCH) && localAck;
    strobe.takeWrite = (state == ST_ACCEPT) && xfer;
    strobe.stepAddr  = ((state == ST_PRESENT) && xfer) || ((state == ST_POST) && localAck);
  end

  assign localReq   = (state == ST_FETCH) || (state == ST_POST);
  assign addrDataOe = state == ST_PRESENT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      prevFrameN <= 1'b1;
      claimN     <= 1'b1;
      slaveRdyN  <= 1'b1;
      haltN      <= 1'b1;
      localWrite <= 1'b0;
      localCfg   <= 1'b0;
      finalSeen  <= 1'b0;
      phaseCnt   <= '0;
    end else begin
      prevFrameN <= cycleFrameN;
      unique case (state)
        ST_IDLE: if (addrPhase && hit) begin
          state      <= ST_DECODE;
          localWrite <= cmdBeN[0];
          localCfg   <= cfgHit && !memHit;
          phaseCnt   <= '0;
        end
        ST_DECODE: begin
          claimN <= 1'b0;
          if (localWrite) begin
            state     <= ST_ACCEPT;
            slaveRdyN <= 1'b0;
            haltN     <= !lastPhase;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: if (localAck) begin
          state     <= ST_PRESENT;
          slaveRdyN <= 1'b0;
          haltN     <= !lastPhase;
        end
        ST_PRESENT: if (xfer) begin
          slaveRdyN <= 1'b1;
          phaseCnt  <= phaseCnt + 1'b1;
          if (cycleFrameN) begin
            state  <= ST_IDLE;
            claimN <= 1'b1;
            haltN  <= 1'b1;
          end else if (lastPhase) begin
            state <= ST_DRAIN;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_ACCEPT: if (xfer) begin
          state     <= ST_POST;
          slaveRdyN <= 1'b1;
          phaseCnt  <= phaseCnt + 1'b1;
          finalSeen <= cycleFrameN;
          if (cycleFrameN) haltN <= 1'b1;
        end
        ST_POST: if (localAck) begin
          if (finalSeen) begin
            state  <= ST_IDLE;
            claimN <= 1'b1;
          end else if (!haltN) begin
            state <= ST_DRAIN;
          end else begin
            state     <= ST_ACCEPT;
            slaveRdyN <= 1'b0;
            haltN     <= !lastPhase;
          end
        end
        ST_DRAIN: if (cycleFrameN) begin
          state  <= ST_IDLE;
          claimN <= 1'b1;
          haltN  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: claimed address phase -> idle one clock, then claim
  a_r3_medium_claim : assert property (@(posedge clk) disable iff (!rstN)
    (addrPhase && hit) |=> (claimN ##1 !claimN));

  // R2: unclaimed address phase leaves the bus alone
  a_r2_miss_ignored : assert property (@(posedge clk) disable iff (!rstN)
    (addrPhase && !hit) |=> (claimN && !localReq));

  // R4: a ready target keeps waiting while the initiator stalls
  a_r4_trdy_held : assert property (@(posedge clk) disable iff (!rstN)
    (!slaveRdyN && masterRdyN) |=> !slaveRdyN);

  // R7: stop and ready only appear inside a claimed cycle
  a_r7_stop_claimed : assert property (@(posedge clk) disable iff (!rstN)
    (!haltN || !slaveRdyN) |-> !claimN);

  // R8: read completed with frame high releases everything
  a_r8_release : assert property (@(posedge clk) disable iff (!rstN)
    (addrDataOe && xfer && cycleFrameN) |=> (claimN && slaveRdyN && haltN));

endmodule

// File: rtl/pci_target_ctrl.sv
module pci_target_ctrl
  import pci_target_pkg::*;
#(
  parameter int          LOCAL_AW  = 12,
  parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
  parameter int          WIN_LOG2  = 12,
  parameter int          BURST_MAX = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         addrDataIn,
  input  logic [3:0]          cmdBeN,
  input  logic                cycleFrameN,
  input  logic                masterRdyN,
  input  logic                cfgSel,
  output logic [31:0]         addrDataOut,
  output logic                addrDataOe,
  output logic                claimN,
  output logic                slaveRdyN,
  output logic                haltN,
  output logic [LOCAL_AW-1:0] localAddr,
  output logic [3:0]          localByteEn,
  output logic [31:0]         localWrData,
  output logic                localWrite,
  output logic                localCfg,
  output logic                localReq,
  input  logic [31:0]         localRdData,
  input  logic                localAck
);

  dpStrobe_t strobe;
  logic      winHit;

  pci_target_fsm #(.BURST_MAX(BURST_MAX)) i_fsm (
    .clk(clk), .rstN(rstN), .cycleFrameN(cycleFrameN), .masterRdyN(masterRdyN),
    .cmdBeN(cmdBeN), .cfgSel(cfgSel), .winHit(winHit), .localAck(localAck),
    .strobe(strobe), .claimN(claimN), .slaveRdyN(slaveRdyN), .haltN(haltN),
    .addrDataOe(addrDataOe), .localReq(localReq), .localWrite(localWrite),
    .localCfg(localCfg)
  );

  pci_target_dp #(.LOCAL_AW(LOCAL_AW), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdMode(!localWrite),
    .addrDataIn(addrDataIn), .cmdBeN(cmdBeN), .localRdData(localRdData),
    .winHit(winHit), .addrDataOut(addrDataOut), .localAddr(localAddr),
    .localByteEn(localByteEn), .localWrData(localWrData)
  );

  // R4: read data on the bus does not move while the initiator stalls
  a_r4_data_stable : assert property (@(posedge clk) disable iff (!rstN)
    (addrDataOe && masterRdyN) |=> $stable(addrDataOut));

  // R5: reads always request all byte lanes
  a_r5_full_lanes : assert property (@(posedge clk) disable iff (!rstN)
    (localReq && !localWrite) |-> (localByteEn == 4'hF));

endmodule

// File: tb/test_pci_target_ctrl.sv
module test_pci_target_ctrl;

  localparam int CLK_NS = 10;
  localparam int LAW    = 8;
  localparam int BURST  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeN = 4'hF;
  logic frameN = 1'b1, irdyN = 1'b1, cfgSel = 1'b0;
  logic [31:0] addrDataOut, localWrData;
  logic addrDataOe, claimN, slaveRdyN, haltN, localWrite, localCfg, localReq;
  logic [LAW-1:0] localAddr;
  logic [3:0] localByteEn;
  logic [31:0] localRdData = '0;
  logic localAck = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pci_target_ctrl #(.LOCAL_AW(LAW), .WIN_BASE(32'h0000_3400), .WIN_LOG2(10),
                    .BURST_MAX(BURST)) i_pci_target_ctrl (
    .clk(clk), .rstN(rstN), .addrDataIn(adIn), .cmdBeN(cbeN), .cycleFrameN(frameN),
    .masterRdyN(irdyN), .cfgSel(cfgSel), .addrDataOut(addrDataOut),
    .addrDataOe(addrDataOe), .claimN(claimN), .slaveRdyN(slaveRdyN), .haltN(haltN),
    .localAddr(localAddr), .localByteEn(localByteEn), .localWrData(localWrData),
    .localWrite(localWrite), .localCfg(localCfg), .localReq(localReq),
    .localRdData(localRdData), .localAck(localAck)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdPat(input logic [7:0] a, input logic c);
    return {a, ~a, a ^ 8'h5A, c ? 8'hC3 : 8'h3C};
  endfunction

  function automatic logic [31:0] wrPat(input int k, input logic [31:0] base);
    return base ^ (32'h0101_0101 * 32'(k + 1)) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [3:0] beN(input int k);
    return 4'(k * 5 + 3);
  endfunction

  // local responder
  int lat = 0, waitCnt = 0, reqSeen = 0, nW = 0;
  logic [7:0]  wA [16];
  logic [31:0] wD [16];
  logic [3:0]  wB [16];
  logic        wC [16];

  always @(negedge clk) begin
    if (!rstN) begin
      localAck = 1'b0;
      waitCnt  = 0;
    end else if (localAck) begin
      localAck = 1'b0;
      waitCnt  = 0;
    end else if (localReq) begin
      reqSeen++;
      if (waitCnt >= lat) begin
        localAck    = 1'b1;
        localRdData = rdPat(localAddr, localCfg);
        if (!localWrite) chk(localByteEn == 4'hF, "R5 read lanes", 32'(localByteEn), 32'hF);
        if (localWrite && nW < 16) begin
          wA[nW] = localAddr; wD[nW] = localWrData; wB[nW] = localByteEn; wC[nW] = localCfg;
          nW++;
        end
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic runTxn(input logic [31:0] addr, input logic [3:0] cmd, input logic cs,
                        input int n, input int mw, input bit expClaim);
    int k = 0, t = 0, claimAt = -1, stopK = -1, waitCtr = 0, reqBefore, expX;
    bit stopped = 0, hold = 0, isWr;
    logic [31:0] holdData = '0;
    logic [7:0] base;
    logic cfgExp;
    isWr = cmd[0];
    base = addr[7:0] & 8'hFC;
    cfgExp = (cmd[3:1] == 3'b101);
    reqBefore = reqSeen;
    nW = 0;
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd; cfgSel = cs;
    while (1) begin
      @(negedge clk);
      t++;
      cfgSel = 1'b0;
      if (!claimN && claimAt < 0) claimAt = t;
      if (hold) begin
        chk(!slaveRdyN && (isWr || addrDataOut == holdData), "R4 hold during stall",
            addrDataOut, holdData);
        hold = 0;
      end
      if (k >= n || stopped || (claimAt < 0 && t > 6) || t > 80) begin
        frameN = 1'b1; irdyN = 1'b1; cbeN = 4'hF;
        break;
      end
      frameN = (k == n - 1);
      cbeN   = beN(k);
      adIn   = isWr ? wrPat(k, addr) : 32'h0;
      if (!slaveRdyN && waitCtr < mw) begin
        irdyN = 1'b1; waitCtr++; hold = 1; holdData = addrDataOut;
      end else begin
        irdyN = 1'b0;
      end
      if (!slaveRdyN && !irdyN) begin
        if (!isWr) chk(addrDataOe && addrDataOut == rdPat(base + 8'(4 * k), cfgExp),
                       "R5 R9 read data", addrDataOut, rdPat(base + 8'(4 * k), cfgExp));
        if (!haltN) begin stopK = k; stopped = 1; end
        k++; waitCtr = 0;
      end else if (!haltN && slaveRdyN) begin
        stopped = 1;
      end
    end
    for (int w = 0; w < 12 && !claimN; w++) @(negedge clk);
    chk(claimN && slaveRdyN && haltN && !addrDataOe, "R8 release",
        {28'h0, claimN, slaveRdyN, haltN, addrDataOe}, 32'hE);
    expX = expClaim ? ((n < BURST) ? n : BURST) : 0;
    chk(k == expX, "R4 R7 phases completed", 32'(k), 32'(expX));
    if (expClaim) begin
      chk(claimAt == 2, "R3 claim timing", 32'(claimAt), 32'd2);
      chk(stopK == ((n >= BURST) ? BURST - 1 : -1), "R7 stop phase", 32'(stopK),
          32'((n >= BURST) ? BURST - 1 : -1));
    end else begin
      chk(claimAt == -1 && reqSeen == reqBefore, "R2 miss ignored", 32'(claimAt), 32'hFFFF_FFFF);
    end
    if (isWr && expClaim) begin
      chk(nW == expX, "R6 write count", 32'(nW), 32'(expX));
      for (int i = 0; i < nW && i < expX; i++) begin
        chk(wA[i] == base + 8'(4 * i), "R6 write addr", 32'(wA[i]), 32'(base + 8'(4 * i)));
        chk(wD[i] == wrPat(i, addr), "R6 write data", wD[i], wrPat(i, addr));
        chk(wB[i] == ~beN(i), "R6 write lanes", 32'(wB[i]), 32'(~beN(i)));
        chk(wC[i] == cfgExp, "R9 cfg flag", 32'(wC[i]), 32'(cfgExp));
      end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(claimN && slaveRdyN && haltN && !addrDataOe && !localReq, "R1 reset state",
        {27'h0, claimN, slaveRdyN, haltN, addrDataOe, localReq}, 32'h1C);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(claimN && slaveRdyN && haltN && !addrDataOe && !localReq, "R1 idle after reset",
        {27'h0, claimN, slaveRdyN, haltN, addrDataOe, localReq}, 32'h1C);

    // decode sweep: every command, window hit/miss, chip select on/off
    lat = 1;
    for (int c = 0; c < 16; c++) begin
      for (int inWin = 0; inWin < 2; inWin++) begin
        for (int cs = 0; cs < 2; cs++) begin
          logic [3:0] cmd;
          bit isMem, isCfg;
          cmd   = 4'(c);
          isMem = (cmd == 4'h6) || (cmd == 4'hC) || (cmd == 4'hE) || (cmd == 4'h7) || (cmd == 4'hF);
          isCfg = (cmd == 4'hA) || (cmd == 4'hB);
          runTxn(inWin != 0 ? 32'h0000_3410 : 32'h0000_3810, cmd, cs[0], 1, 0,
                 (isMem && inWin != 0) || (isCfg && cs != 0));
        end
      end
    end

    // memory bursts: lengths, local latency, initiator stalls, address wrap
    for (int wr = 0; wr < 2; wr++) begin
      for (int n = 1; n <= 6; n++) begin
        for (int l = 0; l < 3; l++) begin
          for (int mw = 0; mw < 2; mw++) begin
            logic [3:0] cmd;
            lat = l;
            if (wr != 0) cmd = n[0] ? 4'hF : 4'h7;
            else cmd = (l == 0) ? 4'h6 : ((l == 1) ? 4'hC : 4'hE);
            runTxn((l == 2) ? 32'h0000_37F8 : 32'h0000_3400 + 32'(n * 16 + mw * 4), cmd, 1'b0, n, mw, 1);
          end
        end
      end
    end

    // configuration bursts
    lat = 1;
    for (int wr = 0; wr < 2; wr++) begin
      for (int n = 1; n <= 5; n++) begin
        runTxn(32'h0000_0040, wr != 0 ? 4'hB : 4'hA, 1'b1, n, n & 1, 1);
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule